// File: doc/BRIEF.md
# Viterbi Butterfly and Traceback Engine

This block decodes a hard-decision convolutional stream with constraint length 7, so the trellis has 64 states. The code rate is 1/2 or 1/3. A frame begins with a start pulse. The pulse carries the stage count and the rate. The engine then takes one group of received code bits per trellis stage. For each stage it works through the 64 states two destinations at a time. One shared add-compare-select unit handles each butterfly in a fixed five-cycle schedule. After every destination state is updated, the engine stores one 64-bit survivor word for that stage.

After the last stage, the engine traces back from state 0, since the encoder is taken to be zero-terminated. It reads one survivor word every three cycles and emits one decoded bit per stage. Bits come out last stage first, and the bit of stage 0 carries a last flag.

Both data streams use valid/ready. On the input side, `in_ready` is high only while the engine is waiting for the next symbol group. A group is taken on the cycle where `in_valid` and `in_ready` are both high. The sender may hold `in_valid` high for as long as it likes. On the output side, the receiver may hold `out_ready` low for any number of cycles. During that time the engine holds the current bit and its last flag steady and does not advance.

Top module: `vit_engine`

## Requirements
- R1: After reset, `in_ready` and `out_valid` are low. `in_ready` stays low while no frame is open, even when `in_valid` is high.
- R2: A `start` pulse is taken only while no frame is open. It opens a frame of `len_m1`+1 stages (1 to 64). A `start` pulse during an open frame has no effect on the frame length or on the output.
- R3: The encoder state s holds the last six input bits. The newest bit is in s[0], and the next state is {s[4:0], b}. Code bit j is the parity of the window {s, b} ANDed with a generator. Window bit 0 is b. Code bit 0 uses octal 171 and goes in `in_sym[0]`. Code bit 1 uses octal 133 and goes in `in_sym[1]`. Code bit 2 uses octal 165 and goes in `in_sym[2]`. With `rate_sel`=0 (rate 1/2), `in_sym[2]` is ignored. With `rate_sel`=1, all three bits count. `rate_sel` is sampled only with `start`.
- R4: After each accepted symbol group, `in_ready` stays low for exactly 160 cycles (32 butterflies of 5 cycles each). It then rises again if the frame has stages left.
- R5: The branch metric is the Hamming distance over the active code bits. Path metrics are 8-bit and saturate at 255. At the start of a frame, state 0 holds 0 and every other state holds 255. After each stage, the minimum metric is subtracted from every state.
- R6: When both candidate paths into a state have equal metrics, the path from the lower-numbered predecessor wins. The predecessors of state n are n>>1 and (n>>1)+32.
- R7: Traceback starts from state 0 after the last stage and only then drives `out_valid`. The output is the decoded bit of each stage, last stage first. `out_last` is high with the bit of stage 0.
- R8: With `out_ready` held high, successive output handshakes of a frame occur exactly 3 cycles apart.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit` and `out_last` hold their values.
- R10: A zero-terminated frame received without errors, or with a single flipped code bit, decodes to the original input bits.
- R11: After the handshake of the last bit, the engine is idle: `out_valid` and `in_ready` are low, and a new `start` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Opens a frame when idle |
| len_m1 | input | 6 | Stage count minus one, sampled with start |
| rate_sel | input | 1 | 0: rate 1/2, 1: rate 1/3, sampled with start |
| in_valid | input | 1 | Symbol group valid |
| in_ready | output | 1 | Engine waits for a symbol group |
| in_sym | input | 3 | Received hard code bits of one stage |
| out_valid | output | 1 | Decoded bit valid |
| out_ready | input | 1 | Receiver takes the decoded bit |
| out_bit | output | 1 | Decoded bit |
| out_last | output | 1 | Marks the bit of stage 0, the last of the frame |

## Verification
Two situations are the hardest to reach from the ports. The first is two candidate paths meeting with exactly equal metrics. The second is metrics of unreachable states pinned at saturation. Clean data almost never produces either one. The stimulus therefore sends long frames with about one code bit in six flipped. The bench scores them against its own full trellis model, which uses the same tie and saturation rules and counts the ties the frame produced. A start pulse injected in the middle of a noisy frame, together with a rate select flipped right after start, shows that frame parameters are held for the whole frame.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int K      = 7;
  localparam int SW     = K - 1;
  localparam int NS     = 1 << SW;
  localparam int NBF    = NS / 2;
  localparam int BF_CYC = 5;
  localparam int TB_CYC = 3;
  localparam int ACS_CYC = NBF * BF_CYC;

  localparam logic [K-1:0] GEN_A = 7'o171;
  localparam logic [K-1:0] GEN_B = 7'o133;
  localparam logic [K-1:0] GEN_C = 7'o165;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACS,
    ST_TB
  } vit_state_e;

  // Expected code bits for a transition out of state s on input bit b.
  function automatic logic [2:0] enc_bits(input logic [SW-1:0] s, input logic b);
    logic [K-1:0] w;
    w = {s, b};
    return {^(w & GEN_C), ^(w & GEN_B), ^(w & GEN_A)};
  endfunction

  // Hamming distance over the active code bits.
  function automatic logic [1:0] hamm(input logic [2:0] c, input logic [2:0] rx, input logic r3);
    logic [2:0] d;
    d = (c ^ rx) & {r3, 2'b11};
    return {1'b0, d[0]} + {1'b0, d[1]} + {1'b0, d[2]};
  endfunction
endpackage

// File: rtl/vit_bmu.sv
module vit_bmu
  import vit_pkg::*;
(
  input  logic [SW-2:0]    bf,
  input  logic [2:0]       rx,
  input  logic             r3,
  output logic [3:0][1:0]  bm
);
  // bm[{hi, b}]: source state {hi, bf}, input bit b
  for (genvar g = 0; g < 4; g++) begin : g_br
    localparam bit HI = (g / 2) == 1;
    localparam bit B  = (g % 2) == 1;
    assign bm[g] = hamm(enc_bits({HI, bf}, B), rx, r3);
  end
endmodule

// File: rtl/vit_acs.sv
module vit_acs #(
  parameter int PM_W = 8
) (
  input  logic                clk,
  input  logic                en_add,
  input  logic                en_sel,
  input  logic [PM_W-1:0]     pa,
  input  logic [PM_W-1:0]     pb,
  input  logic [3:0][1:0]     bm,
  output logic [PM_W-1:0]     m0,
  output logic [PM_W-1:0]     m1,
  output logic                d0,
  output logic                d1
);
  logic [PM_W-1:0] sa0, sa1, sb0, sb1;

  function automatic logic [PM_W-1:0] sat_add(input logic [PM_W-1:0] a, input logic [1:0] b);
    logic [PM_W:0] s;
    s = {1'b0, a} + {{(PM_W-1){1'b0}}, b};
    return s[PM_W] ? '1 : s[PM_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (en_add) begin
      sa0 <= sat_add(pa, bm[0]);
      sa1 <= sat_add(pa, bm[1]);
      sb0 <= sat_add(pb, bm[2]);
      sb1 <= sat_add(pb, bm[3]);
    end
    if (en_sel) begin
      // strict compare: a tie keeps the lower predecessor
      d0 <= sb0 < sa0;
      m0 <= (sb0 < sa0) ? sb0 : sa0;
      d1 <= sb1 < sa1;
      m1 <= (sb1 < sa1) ? sb1 : sa1;
    end
  end
endmodule

// File: rtl/vit_surv.sv
module vit_surv #(
  parameter int AW = 6,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vit_engine.sv
module vit_engine
  import vit_pkg::*;
#(
  parameter int PM_W  = 8,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             rate_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_sym,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit,
  output logic             out_last
);
  vit_state_e       st;
  logic [SW-2:0]    bf;
  logic [2:0]       ph;
  logic [LEN_W-1:0] stg, len_q, tb_stg;
  logic             r3_q;
  logic [2:0]       rx_q;
  logic [SW-1:0]    cs;
  logic [1:0]       tp;
  logic             dbit;

  logic [PM_W-1:0]  pm  [NS];
  logic [PM_W-1:0]  nxt [NS];
  logic [PM_W-1:0]  nxt_c [NS];
  logic [PM_W-1:0]  mn;
  logic [NS-1:0]    decw, dec_nxt;
  logic [PM_W-1:0]  op_pa, op_pb;
  logic [3:0][1:0]  op_bm, bm_w;
  logic [PM_W-1:0]  acs_m0, acs_m1, pair_min;
  logic             acs_d0, acs_d1;
  logic [NS-1:0]    sv_rdata;

  logic accept, in_acs, bf_done, last_bf, step_done, out_fire;

  assign in_ready  = (st == ST_WAIT);
  assign accept    = in_valid && in_ready;
  assign in_acs    = (st == ST_ACS);
  assign bf_done   = in_acs && (ph == 3'(BF_CYC - 1));
  assign last_bf   = (bf == (SW-1)'(NBF - 1));
  assign step_done = bf_done && last_bf;
  assign out_valid = (st == ST_TB) && (tp == 2'(TB_CYC - 1));
  assign out_bit   = cs[0];
  assign out_last  = out_valid && (tb_stg == '0);
  assign out_fire  = out_valid && out_ready;

  vit_bmu u_bmu (
    .bf (bf),
    .rx (rx_q),
    .r3 (r3_q),
    .bm (bm_w)
  );

  vit_acs #(.PM_W(PM_W)) u_acs (
    .clk    (clk),
    .en_add (in_acs && ph == 3'd1),
    .en_sel (in_acs && ph == 3'd2),
    .pa     (op_pa),
    .pb     (op_pb),
    .bm     (op_bm),
    .m0     (acs_m0),
    .m1     (acs_m1),
    .d0     (acs_d0),
    .d1     (acs_d1)
  );

  vit_surv #(.AW(LEN_W), .DW(NS)) u_surv (
    .clk   (clk),
    .we    (step_done),
    .waddr (stg),
    .wdata (dec_nxt),
    .re    (st == ST_TB && tp == 2'd0),
    .raddr (tb_stg),
    .rdata (sv_rdata)
  );

  assign pair_min = (acs_m1 < acs_m0) ? acs_m1 : acs_m0;

  always_comb begin
    nxt_c = nxt;
    nxt_c[{bf, 1'b0}] = acs_m0;
    nxt_c[{bf, 1'b1}] = acs_m1;
    dec_nxt = decw;
    dec_nxt[{bf, 1'b0}] = acs_d0;
    dec_nxt[{bf, 1'b1}] = acs_d1;
  end

  // control sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bf     <= '0;
      ph     <= '0;
      stg    <= '0;
      len_q  <= '0;
      r3_q   <= 1'b0;
      tb_stg <= '0;
      cs     <= '0;
      tp     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st    <= ST_WAIT;
          len_q <= len_m1;
          r3_q  <= rate_sel;
          stg   <= '0;
        end
        ST_WAIT: if (accept) begin
          st <= ST_ACS;
          bf <= '0;
          ph <= '0;
        end
        ST_ACS: begin
          if (bf_done) begin
            ph <= '0;
            bf <= bf + 1'b1;
            if (last_bf) begin
              if (stg == len_q) begin
                st     <= ST_TB;
                tb_stg <= len_q;
                cs     <= '0;
                tp     <= '0;
              end else begin
                stg <= stg + 1'b1;
                st  <= ST_WAIT;
              end
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_TB: begin
          if (tp != 2'(TB_CYC - 1)) begin
            tp <= tp + 1'b1;
          end else if (out_ready) begin
            cs <= {dbit, cs[SW-1:1]};
            tp <= '0;
            if (tb_stg == '0) st <= ST_IDLE;
            else tb_stg <= tb_stg - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // datapath registers
  always_ff @(posedge clk) begin
    if (st == ST_IDLE && start) begin
      for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : '1;
    end
    if (accept) begin
      rx_q <= in_sym;
      mn   <= '1;
    end
    if (in_acs && ph == 3'd0) begin
      op_pa <= pm[{1'b0, bf}];
      op_pb <= pm[{1'b1, bf}];
      op_bm <= bm_w;
    end
    if (in_acs && ph == 3'd3) begin
      if (pair_min < mn) mn <= pair_min;
    end
    if (bf_done) begin
      nxt  <= nxt_c;
      decw <= dec_nxt;
      if (last_bf) begin
        for (int i = 0; i < NS; i++) pm[i] <= nxt_c[i] - mn;
      end
    end
    if (st == ST_TB && tp == 2'd1) dbit <= sv_rdata[cs];
  end
endmodule

// File: rtl/vit_engine_chk.sv
module vit_engine_chk
  import vit_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_last
);
  localparam int GW = $clog2(ACS_CYC + 1);
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else if (in_valid && in_ready) gap <= GW'(ACS_CYC);
    else if (gap != '0) gap <= gap - 1'b1;
  end

  // R4
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap != '0) |-> !in_ready);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

  // R8
  tb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> !out_valid ##1 !out_valid ##1 out_valid);

  // R7
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid && !in_ready));
endmodule

bind vit_engine vit_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .out_last  (out_last)
);

// File: tb/vit_engine_tb.sv
`timescale 1ns/1ps
module vit_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] len_m1 = '0;
  logic       rate_sel = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_sym = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_bit;
  logic       out_last;

  always #4 clk = ~clk;

  vit_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_m1(len_m1),
    .rate_sel(rate_sel), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .out_last(out_last)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;
  logic [1:0] exp_q [$];   // {bit, last}
  bit bp = 0;
  logic [2:0] rx_a [64];
  bit info [64];
  bit ref_o [64];
  bit dv [64][64];
  int ties;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] tb_code(input int s, input bit b);
    logic [6:0] w;
    w = {s[5:0], b};
    return {^(w & 7'o165), ^(w & 7'o133), ^(w & 7'o171)};
  endfunction

  function automatic int tb_bm(input int s, input bit b, input logic [2:0] rx, input bit r3);
    logic [2:0] d;
    d = (tb_code(s, b) ^ rx) & (r3 ? 3'b111 : 3'b011);
    return int'(d[0]) + int'(d[1]) + int'(d[2]);
  endfunction

  // Reference trellis from R5/R6/R7: full 64-state update per stage
  task automatic ref_decode(input int len, input bit r3);
    int pm [64];
    int np [64];
    ties = 0;
    for (int i = 0; i < 64; i++) pm[i] = (i == 0) ? 0 : 255;
    for (int t = 0; t < len; t++) begin
      int mn;
      mn = 255;
      for (int ns = 0; ns < 64; ns++) begin
        int p0, p1, m0, m1;
        p0 = ns >> 1;
        p1 = p0 + 32;
        m0 = pm[p0] + tb_bm(p0, ns[0], rx_a[t], r3);
        m1 = pm[p1] + tb_bm(p1, ns[0], rx_a[t], r3);
        if (m0 > 255) m0 = 255;
        if (m1 > 255) m1 = 255;
        if (m1 < m0) begin np[ns] = m1; dv[t][ns] = 1; end
        else begin np[ns] = m0; dv[t][ns] = 0; if (m1 == m0) ties++; end
        if (np[ns] < mn) mn = np[ns];
      end
      for (int i = 0; i < 64; i++) pm[i] = np[i] - mn;
    end
    begin
      int s;
      s = 0;
      for (int t = len - 1; t >= 0; t--) begin
        ref_o[t] = s[0];
        s = (int'(dv[t][s]) << 5) | (s >> 1);
      end
    end
  endtask

  // out_ready driver
  initial begin
    forever begin
      @(posedge clk); #2;
      out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // Monitor / scoreboard
  initial begin
    bit hold_pend, hold_bit, prev_ok;
    int last_hs;
    hold_pend = 0; hold_bit = 0; prev_ok = 0; last_hs = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_pend) begin
          // R9 held output under back-pressure
          chk(out_valid && out_bit == hold_bit, "R9", "held bit", int'(out_bit), int'(hold_bit));
        end
        hold_pend = out_valid && !out_ready;
        hold_bit  = out_bit;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(0, "R7", "unexpected output bit", int'(out_bit), -1);
          end else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            // R7 order and last flag; R10 decoded value
            chk(out_bit == e[1], "R10", "decoded bit", int'(out_bit), int'(e[1]));
            chk(out_last == e[0], "R7", "last flag", int'(out_last), int'(e[0]));
          end
          if (!bp && prev_ok) chk(cyc - last_hs == 3, "R8", "handshake spacing", cyc - last_hs, 3);
          prev_ok = !out_last;
          last_hs = cyc;
        end
      end
    end
  end

  // mode: 0 clean, 1 single error, 2 noisy
  task automatic run_frame(input int len, input bit r3, input int mode, input bit use_bp, input bit poke);
    int s;
    s = 0;
    for (int t = 0; t < len; t++) begin
      info[t] = (t < len - 6) ? bit'($urandom % 2) : 1'b0;
      rx_a[t] = tb_code(s, info[t]);
      if (!r3) rx_a[t][2] = bit'($urandom % 2);  // R3 ignored bit at rate 1/2
      s = ((s << 1) | int'(info[t])) & 63;
    end
    if (mode == 1) rx_a[len / 2][0] = ~rx_a[len / 2][0];
    if (mode == 2) begin
      for (int t = 0; t < len; t++)
        for (int j = 0; j < (r3 ? 3 : 2); j++)
          if ($urandom % 6 == 0) rx_a[t][j] = ~rx_a[t][j];
      ref_decode(len, r3);
      // R6 stimulus must create equal-metric merges
      chk(ties > 0, "R6", "ties produced by noisy frame", ties, 1);
      for (int t = len - 1; t >= 0; t--) exp_q.push_back({ref_o[t], t == 0});
    end else begin
      for (int t = len - 1; t >= 0; t--) exp_q.push_back({info[t], t == 0});
    end
    bp = use_bp;
    @(posedge clk); #2;
    start = 1; len_m1 = 6'(len - 1); rate_sel = r3;
    @(posedge clk); #2;
    start = 0; rate_sel = ~r3; len_m1 = 6'($urandom);   // R3 rate sampled only with start
    for (int t = 0; t < len; t++) begin
      in_valid = 1; in_sym = rx_a[t];
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #2;
      in_valid = 0; in_sym = 3'($urandom);
      if (poke && t == len / 2) begin
        start = 1; len_m1 = 6'd3;   // R2 must be ignored mid-frame
        @(posedge clk); #2;
        start = 0;
        if (t < len - 1) do @(negedge clk); while (!in_ready);
      end else if (t < len - 1) begin
        int g;
        g = 0;
        forever begin
          @(negedge clk);
          if (in_ready) break;
          g++;
        end
        chk(g == 160, "R4", "ready-low cycles after accept", g, 160);
      end
      @(posedge clk); #2;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    // R11 idle after last bit
    chk(!out_valid && !in_ready, "R11", "idle after frame", int'(out_valid) + 2 * int'(in_ready), 0);
    bp = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog expired: got %0d expected %0d", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(!in_ready, "R1", "in_ready in reset", int'(in_ready), 0);
    chk(!out_valid, "R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1;
    in_valid = 1;
    repeat (5) @(negedge clk);
    chk(!in_ready, "R1", "in_ready without start", int'(in_ready), 0);
    @(posedge clk); #2;
    in_valid = 0;

    run_frame(20, 0, 0, 0, 0);   // R3 rate 1/2 clean
    run_frame(24, 1, 0, 1, 0);   // R3 rate 1/3 clean, R9 back-pressure
    run_frame(30, 0, 1, 0, 0);   // R10 single error corrected
    run_frame(64, 0, 2, 0, 0);   // R5 R6 longest frame, noisy
    run_frame(40, 1, 2, 1, 1);   // R2 start ignored mid-frame, R6 noisy rate 1/3
    run_frame(1, 0, 0, 0, 0);    // R2 shortest frame
    // R11 a new frame is taken after a completed one (covered by the frames above)
    chk(exp_q.size() == 0, "R7", "all expected bits produced", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule